// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It watches two gating trigger inputs of opposite polarity and an active-low clear. When a qualifying edge appears on these inputs, it drives a pulse that lasts a programmable number of clock cycles. The length comes from a binary duration input, which the block samples each time it fires. A qualifying edge that arrives while a pulse is running reloads the full length, so a steady stream of triggers can hold the output high indefinitely. Pulling the clear low stops the pulse at once and blocks all triggering.

All three control inputs pass through a synchronizer chain before edge detection, so they may be fully asynchronous to the clock. The block drives a true output and a separately registered complementary output. Just after reset, edge detection is masked until the synchronizer chain carries real input levels. As a result, levels that happen to satisfy a trigger condition while reset is released never produce a pulse.

Top module: `retrig_oneshot`

## Requirements
- R1: With `gate_lo_n` low and `clear_n` high, a low-to-high transition of `gate_hi` starts a pulse.
- R2: With `gate_hi` high and `clear_n` high, a high-to-low transition of `gate_lo_n` starts a pulse.
- R3: With `gate_lo_n` low and `gate_hi` high, a low-to-high transition of `clear_n` starts a pulse.
- R4: The first rising clock edge that samples a triggering input change is edge 1. `pulse` rises on edge 3 and stays high for exactly `width_cycles` clock cycles, using the value present when the trigger is detected.
- R5: A qualifying trigger during a pulse reloads the count with the current `width_cycles`, so the pulse lasts that many cycles counted from the newest trigger.
- R6: A trigger with `width_cycles` equal to zero produces no pulse, and it ends a pulse already in progress at the same edge where a nonzero reload would take effect.
- R7: Driving `clear_n` low forces `pulse` low on edge 3, counting as in R4, whatever the state of the trigger inputs.
- R8: While `clear_n` is low, edges on `gate_lo_n` and `gate_hi` are ignored and are not remembered once `clear_n` returns high.
- R9: `pulse_n` is always the inverse of `pulse`.
- R10: While `rst` is high, and after it is released, `pulse` is low and `pulse_n` is high. No pulse appears until an input edge occurs after release, even when the held input levels satisfy a trigger condition.
- R11: A rise of `gate_hi` while `gate_lo_n` is high, and a fall of `gate_lo_n` while `gate_hi` is low, do not start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_lo_n | input | 1 | Active-low trigger gate, asynchronous |
| gate_hi | input | 1 | Active-high trigger gate, asynchronous |
| clear_n | input | 1 | Active-low overriding clear, asynchronous |
| width_cycles | input | DUR_W | Pulse length in clock cycles |
| pulse | output | 1 | True pulse output |
| pulse_n | output | 1 | Complementary pulse output |

## Verification
The assertions assume that `width_cycles` is stable whenever a trigger can be detected, because the value is not synchronized. The stimulus therefore changes the duration only on the same falling edge as the trigger input, two full cycles before the value is sampled. The assertions also assume that every input change stays in place for longer than the synchronizer depth. The bench changes inputs on falling clock edges and holds each level for at least one full cycle before the next change, so no pulse narrower than one cycle reaches the synchronizers.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized control levels, one bit per input
    typedef struct packed {
        logic gate_lo_n;
        logic gate_hi;
        logic clear_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t lvl,
    output logic fire,
    output logic clr_lvl
);

    // Edges are judged only once both the chain and the history register hold real levels
    localparam int ARM    = STAGES + 1;
    localparam int WARM_W = $clog2(ARM + 1);
    localparam logic [WARM_W-1:0] ARM_V = WARM_W'(ARM);

    typedef struct packed {
        ctl_t              prev;
        logic [WARM_W-1:0] warm;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     armed;
    logic     hi_rise, lo_fall, clr_rise;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (st_q.warm != ARM_V) begin
            st_d.warm = st_q.warm + 1'b1;
        end

        armed    = (st_q.warm == ARM_V);
        hi_rise  = lvl.gate_hi & ~st_q.prev.gate_hi;
        lo_fall  = ~lvl.gate_lo_n & st_q.prev.gate_lo_n;
        clr_rise = lvl.clear_n & ~st_q.prev.clear_n;

        fire = armed & lvl.clear_n &
               ((~lvl.gate_lo_n & hi_rise) |
                (lvl.gate_hi & lo_fall) |
                (~lvl.gate_lo_n & lvl.gate_hi & clr_rise));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_lvl = lvl.clear_n;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             clr_lvl,
    input  logic [DUR_W-1:0] dur,
    output logic             q,
    output logic             qn
);

    typedef struct packed {
        logic [DUR_W-1:0] cnt;
        logic             out;
        logic             out_n;
    } tmr_st_t;

    localparam tmr_st_t IDLE = '{cnt: '0, out: 1'b0, out_n: 1'b1};

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!clr_lvl) begin
            st_d.cnt = '0;
        end else if (fire) begin
            st_d.cnt = dur;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.out   = (st_d.cnt != '0);
        st_d.out_n = (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign q  = st_q.out;
    assign qn = st_q.out_n;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int DUR_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_lo_n,
    input  logic             gate_hi,
    input  logic             clear_n,
    input  logic [DUR_W-1:0] width_cycles,
    output logic             pulse,
    output logic             pulse_n
);

    ctl_t raw_w, sync_w;
    logic fire_w;
    logic clr_w;

    assign raw_w = '{gate_lo_n: gate_lo_n, gate_hi: gate_hi, clear_n: clear_n};

    oneshot_sync #(
        .STAGES(STAGES),
        .W     (CTL_W)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_w),
        .dout(sync_w)
    );

    oneshot_edge #(
        .STAGES(STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl    (sync_w),
        .fire   (fire_w),
        .clr_lvl(clr_w)
    );

    oneshot_timer #(
        .DUR_W(DUR_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire_w),
        .clr_lvl(clr_w),
        .dur    (width_cycles),
        .q      (pulse),
        .qn     (pulse_n)
    );

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int DUR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic             clr_lvl,
    input logic [DUR_W-1:0] dur,
    input logic             q,
    input logic             qn
);

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        qn == !q);  // R9

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!q && qn));  // R10

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        !clr_lvl |=> !q);  // R7

    AST_CLEAR_MASKS: assert property (@(posedge clk) disable iff (rst)
        !clr_lvl |-> !fire);  // R8

    AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (fire && dur != '0) |=> q);  // R4

    AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (fire && dur == '0) |=> !q);  // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!fire && !q) |=> !q);  // R10

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.DUR_W(DUR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire_w),
    .clr_lvl(clr_w),
    .dur    (width_cycles),
    .q      (pulse),
    .qn     (pulse_n)
);

// File: tb/retrig_oneshot_tb.sv
`timescale 1ns/1ps
module retrig_oneshot_tb;

    localparam int DUR_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gate_lo_n = 1'b0;
    logic             gate_hi = 1'b1;
    logic             clear_n = 1'b1;
    logic [DUR_W-1:0] width_cycles = 8'd4;
    logic             pulse, pulse_n;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    retrig_oneshot #(.DUR_W(DUR_W), .STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .gate_lo_n(gate_lo_n), .gate_hi(gate_hi),
        .clear_n(clear_n), .width_cycles(width_cycles),
        .pulse(pulse), .pulse_n(pulse_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Counts consecutive high samples starting with the current one
    task automatic count_high(output int n);
        n = 0;
        while (pulse && n < 400) begin
            n++;
            step();
        end
    endtask

    task automatic expect_low(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            chk(pulse == 1'b0, req, int'(pulse), 0);
            step();
        end
    endtask

    // R9 checked on every sample out of reset
    always @(negedge clk) begin
        if (!rst) chk(pulse_n == !pulse, "R9", int'(pulse_n), int'(!pulse));
    end

    task automatic t_reset;
        // levels that satisfy a trigger condition are held through reset release
        gate_lo_n = 1'b0; gate_hi = 1'b1; clear_n = 1'b1;
        rst = 1'b1;
        step(4);
        chk(pulse == 1'b0 && pulse_n == 1'b1, "R10 in reset", int'(pulse), 0);
        rst = 1'b0;
        expect_low(12, "R10 after release");
    endtask

    task automatic t_non_trigger;
        int n;
        gate_lo_n = 1'b1; gate_hi = 1'b0; step(4);
        gate_hi = 1'b1; expect_low(6, "R11 hi rise with lo_n high");
        gate_hi = 1'b0; step(4);
        gate_lo_n = 1'b0; expect_low(6, "R11 lo_n fall with hi low");
        // R1: gate_hi rises with gate_lo_n low
        width_cycles = 8'd7; gate_hi = 1'b1;
        step(2);
        chk(pulse == 1'b0, "R4 still low before edge 3", int'(pulse), 0);
        step();
        chk(pulse == 1'b1, "R1 pulse rises on edge 3", int'(pulse), 1);
        count_high(n);
        chk(n == 7, "R1 R4 pulse length", n, 7);
    endtask

    task automatic t_a_fall;
        int n;
        gate_lo_n = 1'b1; gate_hi = 1'b1; step(4);
        width_cycles = 8'd3; gate_lo_n = 1'b0;
        step(3);
        count_high(n);
        chk(n == 3, "R2 pulse length", n, 3);
        // width above 8 bits' midpoint
        gate_lo_n = 1'b1; step(3);
        width_cycles = 8'd200; gate_lo_n = 1'b0;
        step(3);
        count_high(n);
        chk(n == 200, "R2 R4 long pulse", n, 200);
    endtask

    task automatic t_retrigger;
        int n;
        gate_lo_n = 1'b0; gate_hi = 1'b0; step(4);
        width_cycles = 8'd6; gate_hi = 1'b1;
        step(3);
        chk(pulse == 1'b1, "R5 first pulse up", int'(pulse), 1);
        gate_lo_n = 1'b1;
        step(2);
        gate_lo_n = 1'b0; width_cycles = 8'd8;
        step();
        count_high(n);
        chk(n + 3 == 13, "R5 restart total length", n + 3, 13);
        // zero-width retrigger ends a running pulse
        gate_lo_n = 1'b1; gate_hi = 1'b0; step(4);
        gate_lo_n = 1'b0; step(4);
        width_cycles = 8'd10; gate_hi = 1'b1;
        step(3);
        gate_lo_n = 1'b1;
        step(2);
        gate_lo_n = 1'b0; width_cycles = 8'd0;
        step();
        count_high(n);
        chk(n + 3 == 5, "R6 zero retrigger ends pulse", n + 3, 5);
        expect_low(4, "R6 stays low");
        // zero width from idle
        gate_hi = 1'b0; step(4);
        gate_hi = 1'b1; expect_low(8, "R6 zero width no pulse");
    endtask

    task automatic t_clear;
        int n;
        gate_lo_n = 1'b0; gate_hi = 1'b0; step(4);
        width_cycles = 8'd20; gate_hi = 1'b1;
        step(5);
        clear_n = 1'b0;
        step();
        chk(pulse == 1'b1, "R7 high after edge 1", int'(pulse), 1);
        step();
        chk(pulse == 1'b1, "R7 high after edge 2", int'(pulse), 1);
        step();
        chk(pulse == 1'b0, "R7 low on edge 3", int'(pulse), 0);
        // triggers while clear is low
        gate_hi = 1'b0; step(3);
        gate_hi = 1'b1; expect_low(5, "R8 hi rise during clear");
        gate_lo_n = 1'b1; step(3);
        gate_lo_n = 1'b0; expect_low(5, "R8 lo_n fall during clear");
        // release with gate_hi low: nothing pending
        gate_hi = 1'b0; step(3);
        clear_n = 1'b1; expect_low(6, "R8 no remembered edge");
        // R3: clear rises with lo_n low, hi high
        clear_n = 1'b0; gate_hi = 1'b1; step(4);
        width_cycles = 8'd5; clear_n = 1'b1;
        step(3);
        chk(pulse == 1'b1, "R3 clear rise fires on edge 3", int'(pulse), 1);
        count_high(n);
        chk(n == 5, "R3 pulse length", n, 5);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_non_trigger();
        t_a_fall();
        t_retrigger();
        t_clear();
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule